// File: doc/BRIEF.md
# Fixed-Size Test Packet Framer with Comma Guard Gap

This block turns one host port into a source of synthetic traffic. Once started, it emits back-to-back packets of one fixed size, each made of a five-byte header followed by a run of payload bytes. A gap of comma idle symbols separates each packet from the next. The number of guard bytes in that gap is programmable and is the knob that sets the offered load. Whatever guard length is programmed, the block never lets the gap shrink below a hard floor of 17 bytes.

The header is sent in this order: two fixed sync bytes, the destination port, the source port, and the payload length. The destination is drawn from a free-running 16-bit LFSR. It is masked to the port-address width and is never equal to the block's own source address. Every output byte comes with a control flag, so the stream can feed an 8b/10b encoder directly. Commas carry the flag and header and payload bytes do not.

The configuration is sampled when the stream starts and is held for the whole run. A stop request never cuts a packet short. The stream ends only after the current packet and its trailing gap have gone out.

Top module: `fpg_framer`

## Requirements
- R1: After reset, and at any time no stream is running, `tx_data_o` is the comma code 0xBC with `tx_k_o` = 1, `tx_sop_o` = 0 and `busy_o` = 0.
- R2: Each packet opens with 0xA5, then 0x3C, then the destination byte, then the source address zero-extended to 8 bits, all with `tx_k_o` = 0. `tx_sop_o` is 1 on the 0xA5 byte only.
- R3: The fifth header byte equals the payload byte count. It is followed by exactly that many payload bytes with `tx_k_o` = 0, whose values count 0, 1, 2, ... from the start of each packet. A count of zero sends the header alone.
- R4: After each packet's last byte, exactly the programmed number of guard bytes follow, each 0xBC with `tx_k_o` = 1. The next packet's 0xA5 byte comes in the very next cycle, with no extra idle cycle.
- R5: A programmed guard length below 17, including 0, gives a gap of exactly 17 comma bytes.
- R6: The destination byte is below 2^ADDR_W (upper bits zero) and never equals the source address. Over many packets, every other port address appears.
- R7: Source, payload count and guard length are sampled in the cycle `start_i` is seen while idle. Changes to those inputs during a run have no effect, so every packet of a run has the same size and gap.
- R8: `start_i` while idle makes `busy_o` go high and the first 0xA5 byte appear in the next cycle. `start_i` while running has no effect.
- R9: `stop_i` while running ends the stream after the current packet and its full guard gap, with `busy_o` falling right after the last guard byte. This also holds when `stop_i` arrives on that last guard byte. `stop_i` while idle has no effect and is not remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a stream (used while idle) |
| stop_i | input | 1 | Request an end of stream after the current packet and gap |
| src_addr_i | input | ADDR_W | Own port address, sent in the header |
| pay_len_i | input | LEN_W | Payload byte count per packet |
| guard_len_i | input | GUARD_W | Requested guard byte count between packets |
| tx_data_o | output | 8 | Output byte |
| tx_k_o | output | 1 | 1 = control symbol (comma), 0 = data |
| tx_sop_o | output | 1 | First byte of a packet |
| busy_o | output | 1 | A stream is running |

## Verification
The bench uses the default parameters: a 2-bit port address, 8-bit payload and guard counts, and a floor of 17. With only four ports, it can step through every source address. For each one it sweeps payload counts of 0, 1, 3 and 17 and guard requests on both sides of the floor (0, 5, 16, 17, 18, 40). The small address space means every non-self destination shows up within a few dozen packets. Because of that, the exclusion and coverage of destinations can be checked outright, while the rest of the stream is predicted byte by byte from the period 5 + payload + effective guard.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

  localparam logic [7:0] COMMA_SYM = 8'hBC;
  localparam logic [7:0] SYNC_HI   = 8'hA5;
  localparam logic [7:0] SYNC_LO   = 8'h3C;
  localparam int         HDR_BYTES = 5;
  localparam int         DST_SLOT  = 2;
  localparam int         SRC_SLOT  = 3;
  localparam int         LEN_SLOT  = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_PAY  = 2'd2,
    ST_GAP  = 2'd3
  } fpg_state_e;

  // effective guard length: requested value, raised to the floor
  function automatic int unsigned clamp_guard(input int unsigned req,
                                              input int unsigned floor_v);
    return (req < floor_v) ? floor_v : req;
  endfunction

  function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpg_lfsr.sv
module fpg_lfsr #(
  parameter int             W     = 16,
  parameter logic [W-1:0]   TAPS  = 16'hB400,
  parameter logic [W-1:0]   SEED  = 16'h1D2B,
  parameter int             OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd_o
);

  logic [W-1:0] state_q;

  // Galois step, shift right, feedback on the bit leaving at position 0
  function automatic logic [W-1:0] step(input logic [W-1:0] s);
    return {1'b0, s[W-1:1]} ^ (s[0] ? TAPS : '0);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= step(state_q);
  end

  assign rnd_o = state_q[OUT_W-1:0];

endmodule

// File: rtl/fpg_dest_pick.sv
module fpg_dest_pick #(
  parameter int ADDR_W = 2
) (
  input  logic [2*ADDR_W-1:0] rnd_i,
  input  logic [ADDR_W-1:0]   src_i,
  output logic [ADDR_W-1:0]   dest_o
);

  logic [ADDR_W-1:0] cand;
  logic [ADDR_W-1:0] alt;
  logic [ADDR_W-1:0] alt_nz;

  assign cand   = rnd_i[ADDR_W-1:0];
  assign alt    = rnd_i[2*ADDR_W-1:ADDR_W];
  assign alt_nz = (alt == '0) ? ADDR_W'(1) : alt;

  // a nonzero xor always moves a self-addressed draw off the source
  assign dest_o = (cand == src_i) ? (cand ^ alt_nz) : cand;

endmodule

// File: rtl/fpg_seq.sv
module fpg_seq
  import fpg_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int GUARD_W = 8,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [LEN_W-1:0]   pay_len_i,
  input  logic [GUARD_W-1:0] guard_i,
  output fpg_state_e         state_o,
  output logic [CNT_W-1:0]   idx_o,
  output logic               busy_o,
  output logic               launch_o,
  output logic               pkt_begin_o,
  output logic               gap_last_o
);

  fpg_state_e       state_q, state_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             stop_q, stop_d;
  logic             hdr_last, pay_last, gap_last, stop_now;

  assign hdr_last = (state_q == ST_HDR) && (idx_q == CNT_W'(HDR_BYTES - 1));
  assign pay_last = (state_q == ST_PAY) && (idx_q == CNT_W'(pay_len_i - 1'b1));
  assign gap_last = (state_q == ST_GAP) && (idx_q == CNT_W'(guard_i - 1'b1));
  assign stop_now = stop_q | stop_i;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q + 1'b1;
    case (state_q)
      ST_IDLE: begin
        idx_d = '0;
        if (start_i) state_d = ST_HDR;
      end
      ST_HDR: begin
        if (hdr_last) begin
          idx_d   = '0;
          state_d = (pay_len_i == '0) ? ST_GAP : ST_PAY;
        end
      end
      ST_PAY: begin
        if (pay_last) begin
          idx_d   = '0;
          state_d = ST_GAP;
        end
      end
      ST_GAP: begin
        if (gap_last) begin
          idx_d   = '0;
          state_d = stop_now ? ST_IDLE : ST_HDR;
        end
      end
      default: begin
        idx_d   = '0;
        state_d = ST_IDLE;
      end
    endcase
  end

  // stop is remembered only while a stream runs, and cleared as it ends
  always_comb begin
    if (state_q == ST_IDLE || gap_last) stop_d = 1'b0;
    else                                stop_d = stop_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      stop_q  <= stop_d;
    end
  end

  assign state_o     = state_q;
  assign idx_o       = idx_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign launch_o    = (state_q == ST_IDLE) && start_i;
  assign pkt_begin_o = launch_o || (gap_last && !stop_now);
  assign gap_last_o  = gap_last;

endmodule

// File: rtl/fpg_byte_mux.sv
module fpg_byte_mux
  import fpg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  fpg_state_e       state_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic [7:0]       dest_i,
  input  logic [7:0]       src_i,
  input  logic [7:0]       len_i,
  output logic [7:0]       data_o,
  output logic             k_o,
  output logic             sop_o
);

  always_comb begin
    data_o = COMMA_SYM;
    k_o    = 1'b1;
    sop_o  = 1'b0;
    case (state_i)
      ST_HDR: begin
        k_o = 1'b0;
        case (idx_i[2:0])
          3'd0:              begin data_o = SYNC_HI; sop_o = 1'b1; end
          3'd1:              data_o = SYNC_LO;
          3'(DST_SLOT):      data_o = dest_i;
          3'(SRC_SLOT):      data_o = src_i;
          3'(LEN_SLOT):      data_o = len_i;
          default:           data_o = COMMA_SYM;
        endcase
      end
      ST_PAY: begin
        k_o    = 1'b0;
        data_o = idx_i[7:0];
      end
      default: begin
        data_o = COMMA_SYM;
        k_o    = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/fpg_framer.sv
module fpg_framer
  import fpg_pkg::*;
#(
  parameter int            ADDR_W    = 2,
  parameter int            LEN_W     = 8,
  parameter int            GUARD_W   = 8,
  parameter int            MIN_GUARD = 17,
  parameter logic [15:0]   SEED      = 16'h1D2B
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [ADDR_W-1:0]  src_addr_i,
  input  logic [LEN_W-1:0]   pay_len_i,
  input  logic [GUARD_W-1:0] guard_len_i,
  output logic [7:0]         tx_data_o,
  output logic               tx_k_o,
  output logic               tx_sop_o,
  output logic               busy_o
);

  localparam int CNT_W = max_w(max_w(LEN_W, GUARD_W), 8);
  localparam int RND_W = 2 * ADDR_W;

  fpg_state_e         st;
  logic [CNT_W-1:0]   idx;
  logic               launch, pkt_begin, ev_gap_last;
  logic               ev_dest_slot;
  logic [ADDR_W-1:0]  src_q, dest_q, dest_pick;
  logic [LEN_W-1:0]   pay_q;
  logic [GUARD_W-1:0] guard_q;
  logic [RND_W-1:0]   rnd;

  fpg_lfsr #(.W(16), .TAPS(16'hB400), .SEED(SEED), .OUT_W(RND_W)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .rnd_o (rnd)
  );

  // the destination is drawn against the source that is live for the next packet
  logic [ADDR_W-1:0] src_next;
  assign src_next = launch ? src_addr_i : src_q;

  fpg_dest_pick #(.ADDR_W(ADDR_W)) u_pick (
    .rnd_i  (rnd),
    .src_i  (src_next),
    .dest_o (dest_pick)
  );

  fpg_seq #(.LEN_W(LEN_W), .GUARD_W(GUARD_W), .CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .pay_len_i   (pay_q),
    .guard_i     (guard_q),
    .state_o     (st),
    .idx_o       (idx),
    .busy_o      (busy_o),
    .launch_o    (launch),
    .pkt_begin_o (pkt_begin),
    .gap_last_o  (ev_gap_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q   <= '0;
      pay_q   <= '0;
      guard_q <= GUARD_W'(MIN_GUARD);
      dest_q  <= '0;
    end else begin
      if (launch) begin
        src_q   <= src_addr_i;
        pay_q   <= pay_len_i;
        guard_q <= GUARD_W'(clamp_guard(int'(guard_len_i), MIN_GUARD));
      end
      if (pkt_begin) dest_q <= dest_pick;
    end
  end

  assign ev_dest_slot = (st == ST_HDR) && (idx == CNT_W'(DST_SLOT));

  fpg_byte_mux #(.CNT_W(CNT_W)) u_mux (
    .state_i (st),
    .idx_i   (idx),
    .dest_i  (8'(dest_q)),
    .src_i   (8'(src_q)),
    .len_i   (8'(pay_q)),
    .data_o  (tx_data_o),
    .k_o     (tx_k_o),
    .sop_o   (tx_sop_o)
  );

endmodule

// File: rtl/fpg_framer_chk.sv
module fpg_framer_chk
  import fpg_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int LEN_W     = 8,
  parameter int GUARD_W   = 8,
  parameter int MIN_GUARD = 17
) (
  input logic               clk,
  input logic               rst_n,
  input logic [7:0]         tx_data_o,
  input logic               tx_k_o,
  input logic               tx_sop_o,
  input logic               busy_o,
  input logic               ev_dest_slot,
  input logic               ev_gap_last,
  input logic [ADDR_W-1:0]  src_q,
  input logic [LEN_W-1:0]   pay_q,
  input logic [GUARD_W-1:0] guard_q
);

  logic [15:0] k_run;

  always_ff @(posedge clk) begin
    if (!rst_n)                 k_run <= '0;
    else if (busy_o && tx_k_o)  k_run <= k_run + 1'b1;
    else                        k_run <= '0;
  end

  // R1
  idle_comma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (tx_k_o && tx_data_o == COMMA_SYM && !tx_sop_o));

  // R2
  sop_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sop_o |-> (!tx_k_o && tx_data_o == SYNC_HI));

  // R2
  sync_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sop_o |=> (!tx_k_o && tx_data_o == SYNC_LO && !tx_sop_o));

  // R6
  dest_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dest_slot |-> (tx_data_o != 8'(src_q) && (tx_data_o >> ADDR_W) == 8'd0));

  // R5
  min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sop_o && k_run != 16'd0) |-> (k_run >= 16'(MIN_GUARD)));

  // R9
  stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(ev_gap_last));

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(src_q) && $stable(pay_q) && $stable(guard_q)));

endmodule

bind fpg_framer fpg_framer_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .GUARD_W(GUARD_W), .MIN_GUARD(MIN_GUARD)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_data_o    (tx_data_o),
  .tx_k_o       (tx_k_o),
  .tx_sop_o     (tx_sop_o),
  .busy_o       (busy_o),
  .ev_dest_slot (ev_dest_slot),
  .ev_gap_last  (ev_gap_last),
  .src_q        (src_q),
  .pay_q        (pay_q),
  .guard_q      (guard_q)
);

// File: tb/fpg_framer_test.sv
`timescale 1ns/1ps
module fpg_framer_test;

  localparam int ADDR_W    = 2;
  localparam int LEN_W     = 8;
  localparam int GUARD_W   = 8;
  localparam int MIN_GUARD = 17;
  localparam int NPORT     = 1 << ADDR_W;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               start_i, stop_i;
  logic [ADDR_W-1:0]  src_addr_i;
  logic [LEN_W-1:0]   pay_len_i;
  logic [GUARD_W-1:0] guard_len_i;
  logic [7:0]         tx_data_o;
  logic               tx_k_o, tx_sop_o, busy_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit seen [NPORT][NPORT];

  always #4 clk = ~clk;

  fpg_framer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .GUARD_W(GUARD_W),
               .MIN_GUARD(MIN_GUARD)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .src_addr_i(src_addr_i), .pay_len_i(pay_len_i), .guard_len_i(guard_len_i),
    .tx_data_o(tx_data_o), .tx_k_o(tx_k_o), .tx_sop_o(tx_sop_o), .busy_o(busy_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string req, input string what);
    check(!busy_o && tx_k_o && !tx_sop_o && tx_data_o == 8'hBC, req, what,
          {busy_o, tx_k_o, tx_sop_o, tx_data_o}, {3'b010, 8'hBC});
  endtask

  task automatic run(input int src, input int plen, input int guard, input int npk,
                     input bit stop_late, input bit mid_start);
    int geff  = (guard < MIN_GUARD) ? MIN_GUARD : guard;
    int per   = 5 + plen + geff;
    int total = npk * per;
    @(negedge clk);
    src_addr_i = ADDR_W'(src); pay_len_i = LEN_W'(plen); guard_len_i = GUARD_W'(guard);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R7: scribble the configuration inputs while the run is going
    src_addr_i = ADDR_W'(src + 1); pay_len_i = LEN_W'(plen + 9); guard_len_i = GUARD_W'(guard + 3);
    for (int c = 0; c < total; c++) begin
      int o = c % per;
      int exp_d;
      bit exp_k, exp_s;
      string req;
      exp_s = (o == 0);
      exp_k = 1'b0;
      if (o == 0)            begin exp_d = 8'hA5; req = "R2"; end
      else if (o == 1)       begin exp_d = 8'h3C; req = "R2"; end
      else if (o == 2)       begin exp_d = tx_data_o; req = "R6"; end
      else if (o == 3)       begin exp_d = src; req = "R2"; end
      else if (o == 4)       begin exp_d = plen; req = "R3"; end
      else if (o < 5 + plen) begin exp_d = o - 5; req = "R3"; end
      else begin
        exp_d = 8'hBC; exp_k = 1'b1;
        req = (guard < MIN_GUARD) ? "R5" : "R4";
      end
      if (c == 0) check(busy_o, "R8", "busy after start", busy_o, 1);
      if (c >= per && o == 0) req = "R4";
      if (c > 0 && c < per) req = (o >= 5 + plen) ? req : ((req == "R2") ? "R7" : req);
      check(busy_o && tx_data_o == 8'(exp_d) && tx_k_o == exp_k && tx_sop_o == exp_s,
            req, $sformatf("byte %0d of packet %0d", o, c / per),
            {busy_o, tx_k_o, tx_sop_o, tx_data_o}, {1'b1, exp_k, exp_s, 8'(exp_d)});
      if (o == 2) begin
        // R6: in range and never self
        check(tx_data_o < NPORT && tx_data_o != 8'(src), "R6", "destination",
              tx_data_o, src);
        if (tx_data_o < NPORT) seen[src][tx_data_o[ADDR_W-1:0]] = 1'b1;
      end
      stop_i  = stop_late ? (c == total - 1) : (c == (npk - 1) * per);
      start_i = mid_start && (c == 3);
      @(negedge clk);
    end
    stop_i = 1'b0; start_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check_idle("R9", "idle after stop");
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int plens [4]  = '{0, 1, 3, 17};
    int guards [6] = '{0, 5, 16, 17, 18, 40};
    rst_n = 1'b0; start_i = 1'b0; stop_i = 1'b0;
    src_addr_i = '0; pay_len_i = '0; guard_len_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1", "reset state");
    // R9: stop while idle is neither acted on nor remembered
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check_idle("R9", "stop while idle");
      @(negedge clk);
    end
    run(1, 4, 20, 3, 1'b0, 1'b0);
    run(2, 2, 3, 1, 1'b1, 1'b0);
    for (int s = 0; s < NPORT; s++)
      for (int p = 0; p < 4; p++)
        for (int g = 0; g < 6; g++)
          run(s, plens[p], guards[g], 3, g[0], !p[0]);
    // R6: every non-self destination reached from each source
    for (int s = 0; s < NPORT; s++)
      for (int d = 0; d < NPORT; d++)
        if (d != s) check(seen[s][d], "R6", $sformatf("coverage src %0d dest %0d", s, d),
                          seen[s][d], 1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule